// File: doc/BRIEF.md
# Fused Compare-and-Branch Execute Unit

This unit resolves a conditional branch instruction that carries its own relational test. In the execute stage it receives the two operand values that decode has already read, the condition selector and immediate-form flag taken from the instruction word, a signed word displacement, the branch PC and the direction the predictor guessed. It evaluates the signed comparison and, at the same time, forms the taken target with its own adder. The outcome goes to a register stage. When the actual direction disagrees with the guess, a one-cycle flush pulse is raised together with the correct next PC.

Since the comparison is done inside the branch at execute, decode cannot resolve it early. A misprediction therefore costs one cycle more than it would with a separate compare followed by a plain branch. To keep a load that sits just ahead of the branch from stalling it any longer than needed, the unit muxes the memory-stage load result straight into either operand. A small decode-side detector asks for exactly one stall cycle while that load is still one stage away. Every valid branch also reports its PC and resolved direction so the predictor can update.

Top module: `cbr_exec_unit`

## Requirements
- R1: The condition selector `in_cond` is decoded as 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal, and 6 or 7 never taken. The operands are compared as signed 32-bit values, first operand on the left.
- R2: When `in_imm` is 1, the second operand is `in_imm12` zero-extended to 32 bits. In that case `in_opb` and `in_fwd_b` have no effect on the outcome.
- R3: The taken target is `in_pc` plus `in_disp` sign-extended and multiplied by 4. `in_disp` is 20 bits wide, which is 4 bits shorter than a 24-bit plain branch field.
- R4: One clock after a valid branch whose resolved direction differs from `in_pred_taken`, `flush` is 1 for that cycle. `redirect_pc` is then the target if the branch is taken, or the branch PC plus 4 if it is not.
- R5: One clock after a valid branch whose direction matches the prediction, `flush` is 0.
- R6: One clock after every valid branch, `upd_valid` is 1, `upd_taken` gives the resolved direction and `upd_pc` gives the branch PC.
- R7: When `in_fwd_a` is 1, the first operand is `mem_ld_data` instead of `in_opa`. When `in_fwd_b` is 1 and `in_imm` is 0, the second operand is `mem_ld_data` instead of `in_opb`.
- R8: `dec_stall` is 1 in the same cycle exactly when `dec_valid` and `ex_ld_valid` are both 1 and `ex_ld_rd` equals `dec_src_a`, or equals `dec_src_b` while `dec_imm` is 0.
- R9: After reset, `flush`, `upd_valid`, `upd_taken`, `upd_pc` and `redirect_pc` are all 0.
- R10: One clock after a cycle with `in_valid` at 0, `flush` and `upd_valid` are both 0, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A branch occupies the execute stage |
| in_pc | input | 32 | Branch PC |
| in_cond | input | 3 | Relational selector |
| in_imm | input | 1 | Second operand comes from the constant field |
| in_imm12 | input | 12 | Unsigned constant field |
| in_disp | input | 20 | Signed word displacement |
| in_pred_taken | input | 1 | Predicted direction |
| in_opa | input | 32 | First operand read in decode |
| in_opb | input | 32 | Second operand read in decode |
| in_fwd_a | input | 1 | Take the first operand from the memory-stage load |
| in_fwd_b | input | 1 | Take the second operand from the memory-stage load |
| mem_ld_data | input | 32 | Load result in the memory stage |
| dec_valid | input | 1 | A branch occupies decode |
| dec_src_a | input | 4 | First source register index in decode |
| dec_src_b | input | 4 | Second source register index in decode |
| dec_imm | input | 1 | Decode branch uses the constant form |
| ex_ld_valid | input | 1 | A load occupies the execute stage |
| ex_ld_rd | input | 4 | Destination index of that load |
| dec_stall | output | 1 | Hold the decode branch for one cycle |
| flush | output | 1 | Misprediction flush pulse |
| redirect_pc | output | 32 | Correct next PC on a flush |
| upd_valid | output | 1 | Predictor update strobe |
| upd_taken | output | 1 | Resolved direction |
| upd_pc | output | 32 | PC of the resolved branch |

## Verification
Two things can land on the same cycle: a forwarded load value arriving in execute, and a decode-side load-use hazard belonging to a newer branch. Each random vector drives both sides independently, so forwarding, constant form and misprediction coincide with stall requests on arbitrary register indices. Directed vectors add the corners: signed boundary values, the largest constant with a garbage register operand, extreme displacements, and idle cycles. A reference function works out the direction, the target and the stall, and each is compared on the clock where it should appear.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;
  localparam int XLEN   = 32;
  localparam int DISP_W = 20;
  localparam int IMM_W  = 12;
  localparam int RIDX_W = 4;

  typedef enum logic [2:0] {
    RC_EQ  = 3'd0,
    RC_NE  = 3'd1,
    RC_LT  = 3'd2,
    RC_LE  = 3'd3,
    RC_GT  = 3'd4,
    RC_GE  = 3'd5,
    RC_NV0 = 3'd6,
    RC_NV1 = 3'd7
  } rel_cond_e;
endpackage

// File: rtl/cbr_opnd_sel.sv
`timescale 1ns/1ps
module cbr_opnd_sel #(
  parameter int W = 32,
  parameter int K_W = 12,
  parameter bit ALLOW_IMM = 1'b0
) (
  input  logic [W-1:0]   reg_val,
  input  logic [W-1:0]   fwd_val,
  input  logic           use_fwd,
  input  logic           use_k,
  input  logic [K_W-1:0] k_val,
  output logic [W-1:0]   opnd
);
  localparam int PAD = W - K_W;
  logic [W-1:0] k_ext;
  assign k_ext = {{PAD{1'b0}}, k_val};

  generate
    if (ALLOW_IMM) begin : g_imm
      always_comb begin
        if (use_k)        opnd = k_ext;
        else if (use_fwd) opnd = fwd_val;
        else              opnd = reg_val;
      end
    end else begin : g_reg
      always_comb opnd = use_fwd ? fwd_val : reg_val;
    end
  endgenerate
endmodule

// File: rtl/cbr_cmp.sv
`timescale 1ns/1ps
module cbr_cmp
  import cbr_pkg::*;
#(
  parameter int W = 32
) (
  input  rel_cond_e    cond,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         taken
);
  logic eq, lt;
  assign eq = (a == b);
  assign lt = ($signed(a) < $signed(b));

  always_comb begin
    unique case (cond)
      RC_EQ:   taken = eq;
      RC_NE:   taken = !eq;
      RC_LT:   taken = lt;
      RC_LE:   taken = lt || eq;
      RC_GT:   taken = !(lt || eq);
      RC_GE:   taken = !lt;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_target.sv
`timescale 1ns/1ps
module cbr_target #(
  parameter int W = 32,
  parameter int D_W = 20
) (
  input  logic [W-1:0]   pc,
  input  logic [D_W-1:0] disp,
  output logic [W-1:0]   tgt,
  output logic [W-1:0]   seq
);
  localparam int EXT = W - D_W - 2;
  logic [W-1:0] off;
  assign off = {{EXT{disp[D_W-1]}}, disp, 2'b00};
  assign tgt = pc + off;
  assign seq = pc + W'(4);
endmodule

// File: rtl/cbr_hazard.sv
`timescale 1ns/1ps
module cbr_hazard #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic          dec_imm,
  input  logic          ex_ld_valid,
  input  logic [RW-1:0] ex_ld_rd,
  output logic          stall
);
  logic hit_a, hit_b;
  assign hit_a = (ex_ld_rd == dec_src_a);
  assign hit_b = (ex_ld_rd == dec_src_b) && !dec_imm;
  assign stall = dec_valid && ex_ld_valid && (hit_a || hit_b);

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex_ld_valid && dec_valid)); // R8
  AST_IMM_SRCB_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (stall && dec_imm) |-> (ex_ld_rd == dec_src_a)); // R8
endmodule

// File: rtl/cbr_exec_unit.sv
`timescale 1ns/1ps
module cbr_exec_unit
  import cbr_pkg::*;
#(
  parameter int W = XLEN,
  parameter int D_W = DISP_W,
  parameter int K_W = IMM_W,
  parameter int RW = RIDX_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_pc,
  input  logic [2:0]     in_cond,
  input  logic           in_imm,
  input  logic [K_W-1:0] in_imm12,
  input  logic [D_W-1:0] in_disp,
  input  logic           in_pred_taken,
  input  logic [W-1:0]   in_opa,
  input  logic [W-1:0]   in_opb,
  input  logic           in_fwd_a,
  input  logic           in_fwd_b,
  input  logic [W-1:0]   mem_ld_data,
  input  logic           dec_valid,
  input  logic [RW-1:0]  dec_src_a,
  input  logic [RW-1:0]  dec_src_b,
  input  logic           dec_imm,
  input  logic           ex_ld_valid,
  input  logic [RW-1:0]  ex_ld_rd,
  output logic           dec_stall,
  output logic           flush,
  output logic [W-1:0]   redirect_pc,
  output logic           upd_valid,
  output logic           upd_taken,
  output logic [W-1:0]   upd_pc
);
  localparam int NOPND = 2;

  logic [W-1:0] reg_v [NOPND];
  logic         fwd_v [NOPND];
  logic [W-1:0] opnd  [NOPND];

  assign reg_v[0] = in_opa;
  assign reg_v[1] = in_opb;
  assign fwd_v[0] = in_fwd_a;
  assign fwd_v[1] = in_fwd_b;

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    cbr_opnd_sel #(.W(W), .K_W(K_W), .ALLOW_IMM(i == 1)) u_sel (
      .reg_val(reg_v[i]),
      .fwd_val(mem_ld_data),
      .use_fwd(fwd_v[i]),
      .use_k  (in_imm),
      .k_val  (in_imm12),
      .opnd   (opnd[i])
    );
  end

  logic taken;
  cbr_cmp #(.W(W)) u_cmp (
    .cond (rel_cond_e'(in_cond)),
    .a    (opnd[0]),
    .b    (opnd[1]),
    .taken(taken)
  );

  logic [W-1:0] tgt, seq;
  cbr_target #(.W(W), .D_W(D_W)) u_tgt (
    .pc  (in_pc),
    .disp(in_disp),
    .tgt (tgt),
    .seq (seq)
  );

  cbr_hazard #(.RW(RW)) u_haz (
    .clk        (clk),
    .rst        (rst),
    .dec_valid  (dec_valid),
    .dec_src_a  (dec_src_a),
    .dec_src_b  (dec_src_b),
    .dec_imm    (dec_imm),
    .ex_ld_valid(ex_ld_valid),
    .ex_ld_rd   (ex_ld_rd),
    .stall      (dec_stall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush       <= 1'b0;
      redirect_pc <= '0;
      upd_valid   <= 1'b0;
      upd_taken   <= 1'b0;
      upd_pc      <= '0;
    end else begin
      upd_valid <= in_valid;
      flush     <= in_valid && (taken != in_pred_taken);
      if (in_valid) begin
        upd_taken   <= taken;
        upd_pc      <= in_pc;
        redirect_pc <= taken ? tgt : seq;
      end
    end
  end

  AST_UPD_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> upd_valid); // R6
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!upd_valid && !flush)); // R10
  AST_FLUSH_ON_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flush == (upd_taken != $past(in_pred_taken)))); // R4
  AST_SEQ_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (flush && !upd_taken) |-> (redirect_pc == upd_pc + W'(4))); // R4
  AST_FLUSH_HAS_UPD: assert property (@(posedge clk) disable iff (rst)
    flush |-> upd_valid); // R5
endmodule

// File: tb/cbr_exec_unit_tb.sv
`timescale 1ns/1ps
module cbr_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_imm, in_pred_taken, in_fwd_a, in_fwd_b;
  logic [31:0] in_pc, in_opa, in_opb, mem_ld_data;
  logic [2:0]  in_cond;
  logic [11:0] in_imm12;
  logic [19:0] in_disp;
  logic        dec_valid, dec_imm, ex_ld_valid;
  logic [3:0]  dec_src_a, dec_src_b, ex_ld_rd;
  logic        dec_stall, flush, upd_valid, upd_taken;
  logic [31:0] redirect_pc, upd_pc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cbr_exec_unit u_dut (.*);

  function automatic logic ref_taken(logic [2:0] c, logic [31:0] a, logic [31:0] b);
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return $signed(a) < $signed(b);
      3'd3: return $signed(a) <= $signed(b);
      3'd4: return $signed(a) > $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] ref_tgt(logic [31:0] pc, logic [19:0] d);
    return pc + {{10{d[19]}}, d, 2'b00};
  endfunction

  function automatic logic ref_stall();
    return dec_valid && ex_ld_valid &&
           ((ex_ld_rd == dec_src_a) || (!dec_imm && ex_ld_rd == dec_src_b));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a negedge, check outputs at the following negedge
  task automatic vec(logic v, logic [31:0] pc, logic [2:0] c, logic im, logic [11:0] k,
                     logic [19:0] d, logic pr, logic [31:0] a, logic [31:0] b,
                     logic fa, logic fb, logic [31:0] md, string req);
    logic [31:0] ea, eb;
    logic et;
    in_valid = v; in_pc = pc; in_cond = c; in_imm = im; in_imm12 = k; in_disp = d;
    in_pred_taken = pr; in_opa = a; in_opb = b; in_fwd_a = fa; in_fwd_b = fb;
    mem_ld_data = md;
    ea = fa ? md : a;
    eb = im ? {20'd0, k} : (fb ? md : b);
    et = ref_taken(c, ea, eb);
    #1;
    chk("R8 stall", {31'd0, dec_stall}, {31'd0, ref_stall()});
    @(negedge clk);
    chk({req, " upd_valid R6"}, {31'd0, upd_valid}, {31'd0, v});
    if (v) begin
      chk({req, " taken R1"}, {31'd0, upd_taken}, {31'd0, et});
      chk("R6 upd_pc", upd_pc, pc);
      chk({req, " flush R4 R5"}, {31'd0, flush}, {31'd0, et != pr});
      if (et != pr)
        chk("R4 R3 redirect", redirect_pc, et ? ref_tgt(pc, d) : pc + 32'd4);
    end else begin
      chk("R10 idle flush", {31'd0, flush}, 32'd0);
    end
  endtask

  task automatic rand_dec();
    dec_valid = 1'($urandom); dec_imm = 1'($urandom); ex_ld_valid = 1'($urandom);
    dec_src_a = 4'($urandom); dec_src_b = 4'($urandom);
    ex_ld_rd = ($urandom % 3 == 0) ? dec_src_a : 4'($urandom);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    in_valid = 0; in_pc = 0; in_cond = 0; in_imm = 0; in_imm12 = 0; in_disp = 0;
    in_pred_taken = 0; in_opa = 0; in_opb = 0; in_fwd_a = 0; in_fwd_b = 0;
    mem_ld_data = 0; dec_valid = 0; dec_imm = 0; ex_ld_valid = 0;
    dec_src_a = 0; dec_src_b = 0; ex_ld_rd = 0;
    repeat (3) @(negedge clk);
    chk("R9 flush", {31'd0, flush}, 32'd0);
    chk("R9 upd_valid", {31'd0, upd_valid}, 32'd0);
    chk("R9 upd_pc", upd_pc, 32'd0);
    chk("R9 redirect", redirect_pc, 32'd0);
    rst = 1'b0;

    // R1 signed boundary: -1 < 1
    vec(1, 32'h100, 3'd2, 0, 0, 20'd8, 0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R1 lt signed");
    vec(1, 32'h104, 3'd4, 0, 0, 20'd8, 1, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0, "R1 gt min");
    for (int c = 0; c < 8; c++)
      vec(1, 32'h200 + 32'(c * 4), 3'(c), 0, 0, 20'h0_0010, 1, 32'd7, 32'd7, 0, 0, 0, "R1 equal ops");
    // R2 constant form: max constant, register b and fwd_b garbage
    vec(1, 32'h300, 3'd0, 1, 12'hFFF, 20'd4, 0, 32'h0000_0FFF, 32'h1234, 0, 1, 32'h9, "R2 imm max");
    vec(1, 32'h304, 3'd2, 1, 12'h800, 20'd4, 0, 32'hFFFF_F800, 32'h0, 0, 0, 0, "R2 zero-ext");
    // R3 extreme displacements
    vec(1, 32'h1000_0000, 3'd1, 0, 0, 20'h80000, 0, 32'd1, 32'd2, 0, 0, 0, "R3 neg disp");
    vec(1, 32'h1000_0000, 3'd1, 0, 0, 20'h7FFFF, 0, 32'd1, 32'd2, 0, 0, 0, "R3 pos disp");
    // R4 not-taken mispredict -> pc+4
    vec(1, 32'hFFFF_FFFC, 3'd0, 0, 0, 20'd1, 1, 32'd1, 32'd2, 0, 0, 0, "R4 seq wrap");
    // R7 forwarding both operands
    vec(1, 32'h400, 3'd0, 0, 0, 20'd2, 0, 32'd1, 32'd2, 1, 1, 32'hAB, "R7 fwd both");
    vec(1, 32'h404, 3'd3, 0, 0, 20'd2, 0, 32'd50, 32'd3, 1, 0, 32'd3, "R7 fwd a");
    // R10 idle with mismatching garbage
    vec(0, 32'h500, 3'd1, 0, 0, 20'd2, 0, 32'd1, 32'd2, 0, 0, 0, "R10 idle");
    // R8 directed hazard cases
    dec_valid = 1; ex_ld_valid = 1; dec_src_a = 4'd3; dec_src_b = 4'd5; ex_ld_rd = 4'd5; dec_imm = 1;
    vec(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 imm ignores b");
    dec_imm = 0;
    vec(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 hit b");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      rand_dec();
      a = $urandom; b = ($urandom % 4 == 0) ? a : $urandom;
      if ($urandom % 4 == 0) b = a + 32'($signed(2'($urandom)));
      vec(($urandom % 8) != 0, {$urandom, 2'b00}, 3'($urandom), ($urandom % 4) == 0,
          12'($urandom), 20'($urandom), 1'($urandom), a, b,
          ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 2) ? a : $urandom, "rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule